// File: doc/BRIEF.md
# Multiplexed Bus Machine-Cycle Sequencer

This block is the bus front end of a small 8-bit processor that has a 16-bit address space and shares its low address byte with the data byte on one set of lines. The core asks for a machine cycle by giving a cycle kind, an address, write data for stores, and a flag that says whether the address came from the program counter. The sequencer then walks a fixed schedule of clock periods (T-states) for that kind. On the way it drives the upper address byte, the shared address/data lines with their output enable, an address-latch pulse, the active-low read, write and interrupt-acknowledge strobes, and a three-bit status code.

Read-type cycles float the shared lines during their data phase. The byte on the shared lines is captured on the clock edge that closes the third T-state and is handed back with a one-cycle completion pulse. Write-type cycles put their data on the shared lines as soon as the address phase is over. Opcode fetches and interrupt acknowledges take four T-states, or six when the core asks for the long form. Memory and I/O reads and writes take three. The block accepts a request only when it is idle. Between two cycles it always spends at least one idle clock.

Top module: `mux_bus_sequencer`

## Requirements
- R1: While a cycle runs, the status outputs {io_m,s1,s0} hold the code for its kind: fetch 011, memory read 010, memory write 001, I/O read 110, I/O write 101, interrupt acknowledge 111. When idle they read 000. The kind codes on req_kind are fetch 0, memory read 1, memory write 2, I/O read 3, I/O write 4, interrupt acknowledge 5.
- R2: A cycle starts the clock after a request is accepted and keeps `busy` high for its length. The length is 4 T-states for fetch and interrupt acknowledge, or 6 when `req_long` is set. It is 3 T-states for the other four kinds.
- R3: In T1 only, `ale` is high and `ad_out` carries the low address byte with `ad_oe` high. For memory cycles `addr_hi` carries the high address byte throughout the cycle. For I/O cycles the low address byte, which is the port number, appears on both `addr_hi` and `ad_out`.
- R4: `rd_n` is low exactly in T2 and T3 of fetch, memory read and I/O read cycles, and high at all other times.
- R5: In write cycles, `wr_n` is low exactly in T2 and T3, and the write byte is on `ad_out` with `ad_oe` high from T2 to the end of the cycle. `wr_n` is never low in any other kind of cycle.
- R6: An interrupt acknowledge drives `inta_n` low in T2 and T3 in place of `rd_n`, which stays high.
- R7: Outside T1, read-type cycles keep `ad_oe` low. The byte on `ad_in` at the edge that ends T3 appears on `rdata`, together with a one-clock `done` pulse, in the clock that follows T3. Write cycles also pulse `done` at that point.
- R8: `pc_inc` is high during T1 of every fetch, and during T1 of a memory read whose `req_from_pc` is set. It is low at all other times.
- R9: When idle, the strobes are high, `ale` and `ad_oe` are low and `addr_hi` is 0. A request made while a cycle is running has no effect, and a request with kind 6 or 7 is not accepted.
- R10: A synchronous active-high `rst` returns the block to idle within one clock, even in the middle of a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request a machine cycle |
| req_kind | input | 3 | Cycle kind code |
| req_long | input | 1 | Six-T-state form of fetch / interrupt acknowledge |
| req_addr | input | 16 | Cycle address (port number in the low byte for I/O) |
| req_wdata | input | 8 | Byte to write |
| req_from_pc | input | 1 | Address of a memory read came from the program counter |
| ad_in | input | 8 | Shared lines as seen from the pins |
| busy | output | 1 | A cycle is running |
| addr_hi | output | 8 | Upper address lines |
| ad_out | output | 8 | Value driven on the shared lines |
| ad_oe | output | 1 | Output enable of the shared lines |
| ale | output | 1 | Address latch pulse |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inta_n | output | 1 | Interrupt acknowledge strobe, active low |
| io_m | output | 1 | Status: I/O (1) or memory (0) |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| pc_inc | output | 1 | Program counter advance pulse |
| done | output | 1 | Cycle completion pulse |
| rdata | output | 8 | Captured read byte |

## Verification
The assertions watch properties that must hold on every clock, whatever the stimulus:
- the quiet idle bus;
- at most one active strobe at a time;
- a single-clock `ale` only in T1, with `pc_inc` inside it;
- no drive on the shared lines while a read strobe is low, and drive whenever `wr_n` is low;
- status that stays stable across a running cycle;
- `done` as a lone pulse.

Only the bench scenarios can show the full schedule of each kind, which includes:
- the exact length, and the 4 versus 6 T-state choice;
- which byte sits on the address lines for memory and for I/O cycles;
- that the captured byte is the one present at the end of T3;
- that mid-cycle requests, illegal kind codes and a reset in the middle of a cycle leave the expected state behind.

// File: rtl/mbs_pkg.sv
`timescale 1ns/1ps
package mbs_pkg;
  localparam int KIND_W = 3;
  localparam int TS_W   = 3;

  typedef enum logic [KIND_W-1:0] {
    K_FETCH = 3'd0,
    K_MRD   = 3'd1,
    K_MWR   = 3'd2,
    K_IORD  = 3'd3,
    K_IOWR  = 3'd4,
    K_INTA  = 3'd5
  } kind_e;

  typedef struct packed {
    logic io_m;
    logic s1;
    logic s0;
  } status_t;

  function automatic logic kind_ok(input logic [KIND_W-1:0] k);
    return k <= 3'd5;
  endfunction

  function automatic logic [TS_W-1:0] kind_len(input kind_e k, input logic lng);
    case (k)
      K_FETCH, K_INTA: return lng ? 3'd6 : 3'd4;
      default:         return 3'd3;
    endcase
  endfunction

  function automatic status_t kind_status(input kind_e k);
    case (k)
      K_FETCH: return '{io_m: 1'b0, s1: 1'b1, s0: 1'b1};
      K_MRD:   return '{io_m: 1'b0, s1: 1'b1, s0: 1'b0};
      K_MWR:   return '{io_m: 1'b0, s1: 1'b0, s0: 1'b1};
      K_IORD:  return '{io_m: 1'b1, s1: 1'b1, s0: 1'b0};
      K_IOWR:  return '{io_m: 1'b1, s1: 1'b0, s0: 1'b1};
      default: return '{io_m: 1'b1, s1: 1'b1, s0: 1'b1};
    endcase
  endfunction

  function automatic logic kind_uses_rd(input kind_e k);
    return (k == K_FETCH) || (k == K_MRD) || (k == K_IORD);
  endfunction

  function automatic logic kind_writes(input kind_e k);
    return (k == K_MWR) || (k == K_IOWR);
  endfunction

  function automatic logic kind_is_io(input kind_e k);
    return (k == K_IORD) || (k == K_IOWR);
  endfunction

  function automatic logic kind_reads(input kind_e k);
    return kind_uses_rd(k) || (k == K_INTA);
  endfunction
endpackage

// File: rtl/mbs_tstate_ctr.sv
`timescale 1ns/1ps
module mbs_tstate_ctr #(
  parameter int TS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [TS_W-1:0] len_in,
  output logic [TS_W-1:0] tstate,
  output logic            last_t
);
  logic [TS_W-1:0] len_q;

  assign last_t = (tstate != '0) && (tstate == len_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      tstate <= '0;
      len_q  <= '0;
    end else if (tstate == '0) begin
      if (start) begin
        tstate <= TS_W'(1);
        len_q  <= len_in;
      end
    end else if (last_t) begin
      tstate <= '0;
    end else begin
      tstate <= tstate + TS_W'(1);
    end
  end
endmodule

// File: rtl/mbs_bus_drive.sv
`timescale 1ns/1ps
module mbs_bus_drive
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int TS_W   = 3
) (
  input  logic [TS_W-1:0]          tstate,
  input  kind_e                    kind,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     pc_src,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     inta_n,
  output status_t                  status,
  output logic                     pc_inc
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic active, in_t1, in_strobe, is_wr;

  assign active    = (tstate != '0);
  assign in_t1     = (tstate == TS_W'(1));
  assign in_strobe = (tstate == TS_W'(2)) || (tstate == TS_W'(3));
  assign is_wr     = kind_writes(kind);

  always_comb begin
    if (!active)
      addr_hi = '0;
    else if (kind_is_io(kind))
      addr_hi = HI_W'(addr[DATA_W-1:0]);
    else
      addr_hi = addr[ADDR_W-1:DATA_W];
  end

  assign ad_out = in_t1 ? addr[DATA_W-1:0] : (is_wr ? wdata : '0);
  assign ad_oe  = in_t1 || (active && is_wr);
  assign ale    = in_t1;
  assign rd_n   = !(in_strobe && kind_uses_rd(kind));
  assign wr_n   = !(in_strobe && is_wr);
  assign inta_n = !(in_strobe && (kind == K_INTA));
  assign status = active ? kind_status(kind) : '0;
  assign pc_inc = in_t1 && pc_src;
endmodule

// File: rtl/mbs_rdata_cap.sv
`timescale 1ns/1ps
module mbs_rdata_cap #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              end_t3,
  input  logic              take,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      done  <= 1'b0;
    end else begin
      done <= end_t3;
      if (end_t3 && take) rdata <= ad_in;
    end
  end
endmodule

// File: rtl/mux_bus_sequencer.sv
`timescale 1ns/1ps
module mux_bus_sequencer
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic [KIND_W-1:0]        req_kind,
  input  logic                     req_long,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic                     req_from_pc,
  input  logic [DATA_W-1:0]        ad_in,
  output logic                     busy,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     inta_n,
  output logic                     io_m,
  output logic                     s1,
  output logic                     s0,
  output logic                     pc_inc,
  output logic                     done,
  output logic [DATA_W-1:0]        rdata
);
  logic [TS_W-1:0]   t_state;
  logic              t_last;
  logic              accept;
  logic              end_t3;
  kind_e             kind_q;
  kind_e             kind_in;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              pc_src_q;
  status_t           stat;

  assign kind_in = kind_e'(req_kind);
  assign busy    = (t_state != '0);
  assign accept  = req_valid && !busy && kind_ok(req_kind);
  assign end_t3  = (t_state == TS_W'(3));

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q   <= K_FETCH;
      addr_q   <= '0;
      wdata_q  <= '0;
      pc_src_q <= 1'b0;
    end else if (accept) begin
      kind_q   <= kind_in;
      addr_q   <= req_addr;
      wdata_q  <= req_wdata;
      pc_src_q <= (kind_in == K_FETCH) || ((kind_in == K_MRD) && req_from_pc);
    end
  end

  mbs_tstate_ctr #(.TS_W(TS_W)) i_ctr (
    .clk    (clk),
    .rst    (rst),
    .start  (accept),
    .len_in (kind_len(kind_in, req_long)),
    .tstate (t_state),
    .last_t (t_last)
  );

  mbs_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TS_W(TS_W)) i_drive (
    .tstate  (t_state),
    .kind    (kind_q),
    .addr    (addr_q),
    .wdata   (wdata_q),
    .pc_src  (pc_src_q),
    .addr_hi (addr_hi),
    .ad_out  (ad_out),
    .ad_oe   (ad_oe),
    .ale     (ale),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .inta_n  (inta_n),
    .status  (stat),
    .pc_inc  (pc_inc)
  );

  assign io_m = stat.io_m;
  assign s1   = stat.s1;
  assign s0   = stat.s0;

  mbs_rdata_cap #(.DATA_W(DATA_W)) i_cap (
    .clk    (clk),
    .rst    (rst),
    .end_t3 (end_t3),
    .take   (kind_reads(kind_q)),
    .ad_in  (ad_in),
    .rdata  (rdata),
    .done   (done)
  );
endmodule

// File: rtl/mbs_sva.sv
`timescale 1ns/1ps
module mbs_sva #(
  parameter int TS_W = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            busy,
  input logic            ale,
  input logic            ad_oe,
  input logic            rd_n,
  input logic            wr_n,
  input logic            inta_n,
  input logic            io_m,
  input logic            s1,
  input logic            s0,
  input logic            pc_inc,
  input logic            done,
  input logic [TS_W-1:0] tstate,
  input logic            t_last
);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (rd_n && wr_n && inta_n && !ale && !ad_oe));

  a_r4_one_strobe: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> $onehot0({!rd_n, !wr_n, !inta_n}));

  a_r3_ale_single: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);

  a_r3_ale_in_t1: assert property (@(posedge clk) disable iff (rst)
    ale |-> (tstate == TS_W'(1)));

  a_r3_start_with_ale: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ale);

  a_r7_float_on_read: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !inta_n) |-> !ad_oe);

  a_r5_drive_on_write: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> ad_oe);

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r1_status_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable({io_m, s1, s0}));

  a_r8_pc_in_t1: assert property (@(posedge clk) disable iff (rst)
    pc_inc |-> ale);

  a_r2_gap_after_end: assert property (@(posedge clk) disable iff (rst)
    t_last |=> !busy);
endmodule

bind mux_bus_sequencer mbs_sva #(.TS_W(mbs_pkg::TS_W)) i_sva (
  .clk    (clk),
  .rst    (rst),
  .busy   (busy),
  .ale    (ale),
  .ad_oe  (ad_oe),
  .rd_n   (rd_n),
  .wr_n   (wr_n),
  .inta_n (inta_n),
  .io_m   (io_m),
  .s1     (s1),
  .s0     (s0),
  .pc_inc (pc_inc),
  .done   (done),
  .tstate (t_state),
  .t_last (t_last)
);

// File: tb/test_mux_bus_sequencer.sv
`timescale 1ns/1ps
module test_mux_bus_sequencer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [2:0] req_kind = '0;
  logic req_long = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_from_pc = 1'b0;
  logic [7:0] ad_in = '0;
  logic busy, ad_oe, ale, rd_n, wr_n, inta_n, io_m, s1, s0, pc_inc, done;
  logic [7:0] addr_hi, ad_out, rdata;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  mux_bus_sequencer i_mux_bus_sequencer (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_long(req_long), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_from_pc(req_from_pc), .ad_in(ad_in), .busy(busy), .addr_hi(addr_hi),
    .ad_out(ad_out), .ad_oe(ad_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .inta_n(inta_n), .io_m(io_m), .s1(s1), .s0(s0), .pc_inc(pc_inc),
    .done(done), .rdata(rdata)
  );

  typedef struct packed {
    logic [2:0]  kind;
    logic        lng;
    logic [15:0] addr;
    logic [7:0]  wd;
    logic        pc;
    logic [7:0]  rd;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b0, 16'h4105, 8'h00, 1'b1, 8'h34},
    '{3'd0, 1'b1, 16'h2000, 8'h00, 1'b1, 8'h03},
    '{3'd1, 1'b0, 16'h4106, 8'h00, 1'b1, 8'h6A},
    '{3'd1, 1'b1, 16'h526A, 8'h00, 1'b0, 8'hC7},
    '{3'd2, 1'b0, 16'h526A, 8'hC7, 1'b1, 8'h11},
    '{3'd3, 1'b0, 16'h1280, 8'h00, 1'b0, 8'h5A},
    '{3'd4, 1'b0, 16'hFF41, 8'h99, 1'b0, 8'h22},
    '{3'd5, 1'b0, 16'h0000, 8'h00, 1'b0, 8'hFF},
    '{3'd5, 1'b1, 16'h0000, 8'h00, 1'b0, 8'hCF}
  };

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int e_len(input logic [2:0] k, input logic lng);
    if (k == 3'd0 || k == 3'd5) return lng ? 6 : 4;
    return 3;
  endfunction

  function automatic logic [2:0] e_stat(input logic [2:0] k);
    case (k)
      3'd0: return 3'b011;
      3'd1: return 3'b010;
      3'd2: return 3'b001;
      3'd3: return 3'b110;
      3'd4: return 3'b101;
      default: return 3'b111;
    endcase
  endfunction

  task automatic chk_idle(input string req);
    chk(req, "busy", 16'(busy), 16'd0);
    chk(req, "strobes", 16'({rd_n, wr_n, inta_n}), 16'b111);
    chk(req, "ale/oe", 16'({ale, ad_oe}), 16'b00);
    chk(req, "status", 16'({io_m, s1, s0}), 16'd0);
    chk(req, "addr_hi", 16'(addr_hi), 16'd0);
  endtask

  task automatic run_vec(input vec_t v);
    int len;
    logic strobe, is_wr, is_io;
    len = e_len(v.kind, v.lng);
    is_wr = (v.kind == 3'd2) || (v.kind == 3'd4);
    is_io = (v.kind == 3'd3) || (v.kind == 3'd4);
    ad_in = v.rd;
    req_kind = v.kind; req_long = v.lng; req_addr = v.addr;
    req_wdata = v.wd; req_from_pc = v.pc; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int t = 1; t <= len; t++) begin
      strobe = (t == 2) || (t == 3);
      chk("R2", "busy", 16'(busy), 16'd1);
      chk("R1", "status", 16'({io_m, s1, s0}), 16'(e_stat(v.kind)));
      chk("R3", "ale", 16'(ale), 16'(t == 1));
      chk("R3", "addr_hi", 16'(addr_hi), 16'(is_io ? v.addr[7:0] : v.addr[15:8]));
      chk("R4", "rd_n", 16'(rd_n),
          16'(!(strobe && (v.kind == 3'd0 || v.kind == 3'd1 || v.kind == 3'd3))));
      chk("R5", "wr_n", 16'(wr_n), 16'(!(strobe && is_wr)));
      chk("R6", "inta_n", 16'(inta_n), 16'(!(strobe && v.kind == 3'd5)));
      chk("R7", "ad_oe", 16'(ad_oe), 16'((t == 1) || is_wr));
      if (t == 1) chk("R3", "ad low addr", 16'(ad_out), 16'(v.addr[7:0]));
      else if (is_wr) chk("R5", "ad wdata", 16'(ad_out), 16'(v.wd));
      chk("R8", "pc_inc", 16'(pc_inc),
          16'((t == 1) && (v.kind == 3'd0 || (v.kind == 3'd1 && v.pc))));
      chk("R7", "done", 16'(done), 16'(t == 4));
      if (t == 4) chk("R7", "rdata", 16'(rdata), 16'(v.rd));
      @(negedge clk);
    end
    chk_idle("R9");
    chk("R7", "done after", 16'(done), 16'(len == 3));
    if (len == 3 && !is_wr) chk("R7", "rdata", 16'(rdata), 16'(v.rd));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R10");
    chk("R10", "done", 16'(done), 16'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R9: illegal kinds 6 and 7 are not accepted
    for (int k = 6; k < 8; k++) begin
      req_kind = 3'(k); req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9", "illegal kind busy", 16'(busy), 16'd0);
      chk("R9", "illegal kind ale", 16'(ale), 16'd0);
    end

    // R9: request during a running write has no effect
    req_kind = 3'd2; req_addr = 16'h3344; req_wdata = 8'hA5; req_long = 1'b0;
    req_valid = 1'b1;
    @(negedge clk);
    req_kind = 3'd0; req_long = 1'b1; req_addr = 16'h7777;
    @(negedge clk);
    chk("R9", "status kept", 16'({io_m, s1, s0}), 16'b001);
    chk("R9", "wr_n kept", 16'(wr_n), 16'd0);
    chk("R9", "rd_n kept", 16'(rd_n), 16'd1);
    chk("R9", "addr_hi kept", 16'(addr_hi), 16'h33);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9", "wdata kept", 16'(ad_out), 16'hA5);
    @(negedge clk);
    chk("R9", "ended after 3", 16'(busy), 16'd0);
    @(negedge clk);
    chk("R9", "not started later", 16'(busy), 16'd0);

    // R10: reset in the middle of a long fetch
    req_kind = 3'd0; req_long = 1'b1; req_addr = 16'h0100; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R10", "rd_n before reset", 16'(rd_n), 16'd0);
    rst = 1'b1;
    @(negedge clk);
    chk_idle("R10");
    rst = 1'b0;
    @(negedge clk);
    chk("R10", "stays idle", 16'(busy), 16'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule